// File: doc/BRIEF.md
# Register Alias Table Renamer

This block is the rename stage of a small out-of-order core. Each cycle it may accept one micro-op carrying two source register numbers, one destination register number and an operation class. For every architectural register it remembers the youngest in-flight result that will write it, as a tag into a circular pool of reorder-buffer slots, or else that the committed value in the permanent register file is current. Each source comes out either as a producer tag or as a flag telling the core to read the permanent file. The destination is given the next free tag in order.

Retirement frees the oldest tag. The register it wrote falls back to the permanent file only if no younger write has since claimed that register. A self-XOR or self-SUB is treated as a zeroing idiom: its sources depend on nothing, and the new tag is marked as producing zero. A flush discards all speculative state at once.

Top module: `rat_renamer`

## Requirements
- R1: After reset every architectural register reads from the permanent file, in_ready is high, and the first accepted op receives tag 0.
- R2: A source whose register has an in-flight producer is reported with src_perm=0 and that producer's tag. A source with no in-flight producer is reported with src_perm=1.
- R3: Tags are handed out in increasing order modulo TAGS, one per accepted op. The renamed op appears on the outputs with out_valid high on the cycle after it is accepted.
- R4: in_ready is low while all TAGS tags are outstanding. An in_valid offered then is not accepted: no output appears and no tag is consumed.
- R5: Sources are looked up before the destination is remapped, so an op that reads and writes the same register sees the older producer.
- R6: in_op codes are 0 other, 1 XOR, 2 SUB and 3 other. An XOR or SUB whose src0, src1 and dst are all the same register is a zeroing idiom: both sources are reported with src_perm=1, out_dst_zero is 1, and the destination still receives a new tag. Any other op reports out_dst_zero=0.
- R7: ret_valid retires the oldest outstanding tag. The mapping of the register that tag wrote is cleared only if it still holds that tag. Lookups in the same cycle see the mappings from before the retirement.
- R8: flush clears every mapping to the permanent file and empties the tag pool. It takes priority over a rename or retirement in the same cycle, and out_valid is low on the next cycle.
- R9: out_valid is low on any cycle after one in which no op was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all mappings and outstanding tags |
| in_valid | input | 1 | A micro-op is offered |
| in_ready | output | 1 | A free tag exists, so an offered op is accepted |
| in_op | input | 2 | Operation class: 0 other, 1 XOR, 2 SUB, 3 other |
| in_src0 | input | AW | First source register |
| in_src1 | input | AW | Second source register |
| in_dst | input | AW | Destination register |
| ret_valid | input | 1 | Retire the oldest outstanding tag |
| out_valid | output | 1 | Renamed op present |
| out_src0_perm | output | 1 | First source reads the permanent file |
| out_src0_tag | output | TW | Producer tag of the first source |
| out_src1_perm | output | 1 | Second source reads the permanent file |
| out_src1_tag | output | TW | Producer tag of the second source |
| out_dst_tag | output | TW | Tag allocated to the destination |
| out_dst_zero | output | 1 | The destination is a zeroing idiom |

## Verification
The assertions assume that ret_valid is raised only while at least one tag is outstanding. The core retires strictly in order, so the block has no means to refuse a retirement from an empty pool. The bench's reference model tracks its own outstanding count and raises ret_valid only when that count is nonzero, including on cycles that also flush. The tag-sequence property takes for granted that nothing except acceptance moves the allocation pointer. Flush and reset are the only other inputs that touch it, and both force out_valid low on the following cycle.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_XOR   = 2'd1,
    OP_SUB   = 2'd2,
    OP_OTHER = 2'd3
  } rat_op_e;
endpackage

// File: rtl/rat_zero_detect.sv
module rat_zero_detect #(
  parameter int ARCH_REGS = 8,
  localparam int AW = $clog2(ARCH_REGS)
) (
  input  logic [1:0]    op,
  input  logic [AW-1:0] src0,
  input  logic [AW-1:0] src1,
  input  logic [AW-1:0] dst,
  output logic          is_zero
);
  import rat_pkg::*;

  rat_op_e op_e;
  logic    op_clears;

  always_comb begin
    op_e      = rat_op_e'(op);
    op_clears = (op_e == OP_XOR) || (op_e == OP_SUB);
    is_zero   = op_clears && (src0 == src1) && (dst == src0);
  end
endmodule

// File: rtl/rat_tag_pool.sv
module rat_tag_pool #(
  parameter int TAGS = 8,
  parameter int ARCH_REGS = 8,
  localparam int TW = $clog2(TAGS),
  localparam int AW = $clog2(ARCH_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_reg,
  input  logic          free_oldest,
  output logic          has_free,
  output logic [TW-1:0] alloc_tag,
  output logic [TW-1:0] head_tag,
  output logic [AW-1:0] head_reg,
  output logic [TW:0]   count
);
  localparam logic [TW:0] FULL = (TW+1)'(TAGS);

  logic [TW-1:0] head_q, tail_q;
  logic [TW:0]   cnt_q;
  logic [AW-1:0] owner_mem [TAGS];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc)       tail_q <= tail_q + 1'b1;
      if (free_oldest) head_q <= head_q + 1'b1;
      case ({alloc, free_oldest})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // owner register per slot: plain write port, no reset
  always_ff @(posedge clk) begin
    if (alloc) owner_mem[tail_q] <= alloc_reg;
  end

  assign has_free  = (cnt_q != FULL);
  assign alloc_tag = tail_q;
  assign head_tag  = head_q;
  assign head_reg  = owner_mem[head_q];
  assign count     = cnt_q;
endmodule

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int TAGS = 8,
  parameter int ARCH_REGS = 8,
  localparam int TW = $clog2(TAGS),
  localparam int AW = $clog2(ARCH_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] rd0_idx,
  input  logic [AW-1:0] rd1_idx,
  output logic          rd0_live,
  output logic [TW-1:0] rd0_tag,
  output logic          rd1_live,
  output logic [TW-1:0] rd1_tag,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_reg,
  input  logic [TW-1:0] clr_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_reg,
  input  logic [TW-1:0] wr_tag
);
  logic [ARCH_REGS-1:0] live_q;
  logic [TW-1:0]        tag_mem [ARCH_REGS];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      live_q <= '0;
    end else begin
      for (int r = 0; r < ARCH_REGS; r++) begin
        if (wr_en && wr_reg == AW'(r))
          live_q[r] <= 1'b1;
        else if (clr_en && clr_reg == AW'(r) && tag_mem[r] == clr_tag)
          live_q[r] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_reg] <= wr_tag;
  end

  assign rd0_live = live_q[rd0_idx];
  assign rd0_tag  = tag_mem[rd0_idx];
  assign rd1_live = live_q[rd1_idx];
  assign rd1_tag  = tag_mem[rd1_idx];
endmodule

// File: rtl/rat_renamer.sv
module rat_renamer #(
  parameter int TAGS = 8,
  parameter int ARCH_REGS = 8,
  localparam int TW = $clog2(TAGS),
  localparam int AW = $clog2(ARCH_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_src0,
  input  logic [AW-1:0] in_src1,
  input  logic [AW-1:0] in_dst,
  input  logic          ret_valid,
  output logic          out_valid,
  output logic          out_src0_perm,
  output logic [TW-1:0] out_src0_tag,
  output logic          out_src1_perm,
  output logic [TW-1:0] out_src1_tag,
  output logic [TW-1:0] out_dst_tag,
  output logic          out_dst_zero
);
  logic          accept, retire, zero_idiom;
  logic          has_free;
  logic [TW-1:0] new_tag, old_tag;
  logic [AW-1:0] old_reg;
  logic [TW:0]   pool_cnt;
  logic          s0_live, s1_live;
  logic [TW-1:0] s0_tag, s1_tag;

  assign in_ready = has_free;
  assign accept   = in_valid && has_free && !flush;
  assign retire   = ret_valid && !flush;

  rat_zero_detect #(.ARCH_REGS(ARCH_REGS)) i_zero (
    .op(in_op), .src0(in_src0), .src1(in_src1), .dst(in_dst),
    .is_zero(zero_idiom)
  );

  rat_tag_pool #(.TAGS(TAGS), .ARCH_REGS(ARCH_REGS)) i_pool (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc(accept), .alloc_reg(in_dst), .free_oldest(retire),
    .has_free(has_free), .alloc_tag(new_tag),
    .head_tag(old_tag), .head_reg(old_reg), .count(pool_cnt)
  );

  rat_map_table #(.TAGS(TAGS), .ARCH_REGS(ARCH_REGS)) i_map (
    .clk(clk), .rst(rst), .flush(flush),
    .rd0_idx(in_src0), .rd1_idx(in_src1),
    .rd0_live(s0_live), .rd0_tag(s0_tag),
    .rd1_live(s1_live), .rd1_tag(s1_tag),
    .clr_en(retire), .clr_reg(old_reg), .clr_tag(old_tag),
    .wr_en(accept), .wr_reg(in_dst), .wr_tag(new_tag)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid     <= 1'b0;
      out_src0_perm <= 1'b1;
      out_src0_tag  <= '0;
      out_src1_perm <= 1'b1;
      out_src1_tag  <= '0;
      out_dst_tag   <= '0;
      out_dst_zero  <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src0_perm <= zero_idiom || !s0_live;
        out_src0_tag  <= (zero_idiom || !s0_live) ? '0 : s0_tag;
        out_src1_perm <= zero_idiom || !s1_live;
        out_src1_tag  <= (zero_idiom || !s1_live) ? '0 : s1_tag;
        out_dst_tag   <= new_tag;
        out_dst_zero  <= zero_idiom;
      end
    end
  end
endmodule

// File: rtl/rat_renamer_chk.sv
module rat_renamer_chk #(
  parameter int TAGS = 8,
  localparam int TW = $clog2(TAGS)
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          in_valid,
  input logic          in_ready,
  input logic          ret_valid,
  input logic          out_valid,
  input logic          out_src0_perm,
  input logic          out_src1_perm,
  input logic          out_dst_zero,
  input logic [TW-1:0] out_dst_tag,
  input logic [TW:0]   pool_cnt
);
  // R7
  ret_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> pool_cnt != '0);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> !out_valid);

  // R3
  tag_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> out_dst_tag == TW'($past(out_dst_tag) + 1'b1));

  // R6
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dst_zero) |-> (out_src0_perm && out_src1_perm));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && in_ready));

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

bind rat_renamer rat_renamer_chk #(.TAGS(TAGS)) i_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
  .in_ready(in_ready), .ret_valid(ret_valid), .out_valid(out_valid),
  .out_src0_perm(out_src0_perm), .out_src1_perm(out_src1_perm),
  .out_dst_zero(out_dst_zero), .out_dst_tag(out_dst_tag),
  .pool_cnt(pool_cnt)
);

// File: tb/test_rat_renamer.sv
`timescale 1ns/1ps
module test_rat_renamer;
  localparam int TAGS = 8;
  localparam int NREG = 8;
  localparam int TW = $clog2(TAGS);
  localparam int AW = $clog2(NREG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, in_valid = 1'b0, ret_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'd0;
  logic [AW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
  logic out_valid, out_src0_perm, out_src1_perm, out_dst_zero;
  logic [TW-1:0] out_src0_tag, out_src1_tag, out_dst_tag;

  always #5 clk = ~clk;

  rat_renamer #(.TAGS(TAGS), .ARCH_REGS(NREG)) i_rat_renamer (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_op(in_op), .in_src0(in_src0),
    .in_src1(in_src1), .in_dst(in_dst), .ret_valid(ret_valid),
    .out_valid(out_valid), .out_src0_perm(out_src0_perm),
    .out_src0_tag(out_src0_tag), .out_src1_perm(out_src1_perm),
    .out_src1_tag(out_src1_tag), .out_dst_tag(out_dst_tag),
    .out_dst_zero(out_dst_zero)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  bit m_live [NREG];
  int m_tag  [NREG];
  int owner_q[$];
  int m_head = 0, m_tail = 0;

  // last outputs seen, for directed checks
  int last_dst_tag;
  bit last_p0, last_p1;
  int last_t0, last_t1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NREG; r++) begin m_live[r] = 0; m_tag[r] = 0; end
    owner_q.delete();
    m_head = 0; m_tail = 0;
  endtask

  // One cycle: drive, predict, clock, compare.
  task automatic step(bit v, int op, int s0, int s1, int d, bit ret, bit fl, string req);
    bit acc, zero, e_p0, e_p1;
    int e_t0, e_t1, e_dt, r;
    @(negedge clk);
    chk(in_ready == (owner_q.size() < TAGS), "R4", {req, " in_ready"},
        int'(in_ready), int'(owner_q.size() < TAGS));
    in_valid = v; in_op = 2'(op); in_src0 = AW'(s0); in_src1 = AW'(s1);
    in_dst = AW'(d); ret_valid = ret; flush = fl;
    acc = v && !fl && owner_q.size() < TAGS;
    zero = (op == 1 || op == 2) && s0 == s1 && d == s0;
    e_p0 = zero || !m_live[s0]; e_t0 = m_tag[s0];
    e_p1 = zero || !m_live[s1]; e_t1 = m_tag[s1];
    e_dt = m_tail;
    if (fl) model_reset();
    else begin
      if (ret && owner_q.size() > 0) begin
        r = owner_q.pop_front();
        if (m_live[r] && m_tag[r] == m_head) m_live[r] = 0;
        m_head = (m_head + 1) % TAGS;
      end
      if (acc) begin
        m_live[d] = 1; m_tag[d] = m_tail;
        owner_q.push_back(d);
        m_tail = (m_tail + 1) % TAGS;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; ret_valid = 0; flush = 0;
    chk(out_valid == acc, fl ? "R8" : (v ? "R3" : "R9"), {req, " out_valid"},
        int'(out_valid), int'(acc));
    if (acc) begin
      chk(out_src0_perm == e_p0, zero ? "R6" : "R2", {req, " src0_perm"},
          int'(out_src0_perm), int'(e_p0));
      if (!e_p0) chk(int'(out_src0_tag) == e_t0, "R2", {req, " src0_tag"},
          int'(out_src0_tag), e_t0);
      chk(out_src1_perm == e_p1, zero ? "R6" : "R2", {req, " src1_perm"},
          int'(out_src1_perm), int'(e_p1));
      if (!e_p1) chk(int'(out_src1_tag) == e_t1, "R2", {req, " src1_tag"},
          int'(out_src1_tag), e_t1);
      chk(int'(out_dst_tag) == e_dt, "R3", {req, " dst_tag"}, int'(out_dst_tag), e_dt);
      chk(out_dst_zero == zero, "R6", {req, " dst_zero"}, int'(out_dst_zero), int'(zero));
    end
    last_dst_tag = out_dst_tag;
    last_p0 = out_src0_perm; last_p1 = out_src1_perm;
    last_t0 = out_src0_tag;  last_t1 = out_src1_tag;
  endtask

  initial begin
    int seed = 12345;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "no output after reset", int'(out_valid), 0);

    // R1: first op sees only permanent values, gets tag 0
    step(1, 0, 1, 2, 3, 0, 0, "R1");
    chk(last_p0 && last_p1 && last_dst_tag == 0, "R1", "first op perm/tag0",
        last_dst_tag, 0);
    // R2: consumer of r3 sees tag 0
    step(1, 0, 3, 1, 4, 0, 0, "R2");
    chk(!last_p0 && last_t0 == 0, "R2", "consumer tag", last_t0, 0);
    // R5: r4 = r4 op r4 reads older producer tag 1
    step(1, 0, 4, 4, 4, 0, 0, "R5");
    chk(!last_p0 && last_t0 == 1 && last_dst_tag == 2, "R5", "older producer", last_t0, 1);
    // R6: zero idioms and a non-idiom XOR
    step(1, 1, 4, 4, 4, 0, 0, "R6");
    step(1, 2, 3, 3, 3, 0, 0, "R6");
    step(1, 1, 3, 4, 3, 0, 0, "R6");
    step(1, 3, 3, 3, 3, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    // R4: fill pool (7 outstanding -> one more), then stall
    step(1, 0, 5, 6, 7, 0, 0, "R4");
    chk(in_ready == 1'b0, "R4", "full pool", int'(in_ready), 0);
    step(1, 0, 7, 7, 6, 0, 0, "R4");
    step(1, 0, 7, 7, 6, 1, 0, "R4");
    // R7: retire tags; r3 remapped so tag0 retirement leaves r3 live
    step(1, 0, 3, 1, 2, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(1, 0, 1, 2, 5, 0, 0, "R7");
    chk(last_p0, "R7", "r1 never written", int'(last_p0), 1);
    // R8: flush then everything reads permanent file from tag 0
    step(1, 0, 0, 0, 1, 1, 1, "R8");
    step(1, 0, 3, 4, 1, 0, 0, "R8");
    chk(last_p0 && last_p1 && last_dst_tag == 0, "R8", "after flush", last_dst_tag, 0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int op, s0, s1, d;
      bit v, ret, fl;
      seed = seed * 1103515245 + 12345;
      op = (seed >>> 8) & 3; s0 = (seed >>> 12) & 7; s1 = (seed >>> 16) & 7;
      d = (seed >>> 20) & 7;
      if (((seed >>> 24) & 3) == 0) begin s1 = s0; d = s0; end
      v = ((seed >>> 26) & 3) != 0;
      ret = (owner_q.size() > 0) && (((seed >>> 28) & 1) == 1);
      fl = ((seed >>> 3) & 63) == 0;
      step(v, op, s0, s1, d, ret, fl, "R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule